// File: doc/BRIEF.md
# I2C Target Controller with Host Handshake

This block is an I2C target (slave) with a 7-bit own address taken from an input port. It watches the open-drain SCL and SDA lines through a synchronizer clocked by the system clock. It recognises START and STOP conditions, matches the address frame and shifts data bytes in or out. It acknowledges its own address and every byte it receives.

A host reaches the block through a two-location register port: a control/status location and a one-byte data location. Status flags tell the host when a received byte is waiting or when the bus master wants a byte from the target. The flags clear as side effects of accessing the data location. While the host has not serviced a request, the block holds SCL low so the master waits. No byte is lost and no byte is sent before the host supplies it.

A flag marks the first data byte after an address match, so the host can treat that byte as a sub-address or command. A repeated START arms this flag again. Clearing the enable bit detaches the block from the bus.

Top module: `i2cs_target`

## Requirements
- R1: After reset the status word reads 0x00, the block is disabled, and both `scl_oe` and `sda_oe` are 0 (lines released).
- R2: With `reg_sel`=0, a write sets the enable from `reg_wdata[0]`, and a read returns {5'b0, first-byte, transmit-request, receive-request} (bit 2, bit 1, bit 0). With `reg_sel`=1, the access goes to the data byte.
- R3: In the byte after a START, bits 7:1 are the address (MSB first) and bit 0 is the direction (1 = master reads). A match with `own_addr` is acknowledged (SDA low in the 9th clock). A mismatch gets no acknowledge, and the bytes that follow are ignored with the status left at 0x00.
- R4: Each data byte written by the master is acknowledged, appears on the data location, and sets the receive-request bit.
- R5: A host read of the data location clears the receive-request bit and the first-byte bit.
- R6: The first-byte bit is set together with the receive request only for the first data byte after an address match. Later bytes of the same transfer leave it 0.
- R7: A repeated START restarts address matching, and after a new write-address match the next data byte again sets the first-byte bit.
- R8: When a byte's 8th bit ends while the previous byte is still unread, SCL is held low until the host reads the data location. The earlier byte reads back unchanged, and the new byte is then acknowledged and stored.
- R9: A matching read address sets the transmit-request bit and holds SCL low until the host writes the data location. That write clears the bit, and the byte is sent MSB first.
- R10: An acknowledge from the master after a sent byte raises a new transmit request with SCL held. A NACK ends the transfer with no request and SCL released.
- R11: The first-byte bit stays 0 throughout a master-read transfer.
- R12: While disabled, the block never acknowledges or stretches and its status stays 0x00. Disabling clears any pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| own_addr | input | 7 | Own target address |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe (side effects on data location) |
| reg_sel | input | 1 | 0 = control/status, 1 = data |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data |

## Verification
The bench builds the block with a three-stage line synchronizer and own address 0x5A. The longer synchronizer delays every edge the target reacts to, which tests whether its SDA changes and SCL holds still land inside the master's low phase. The address vectors include near misses: the address one higher, the address shifted right, and the address with only its top bit changed, so a partial compare is exposed. Stalls on both receive and transmit are held for many cycles before the host services them.

// File: rtl/i2cs_pkg.sv
`timescale 1ns/1ps
package i2cs_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    localparam logic SEL_CTRL = 1'b0;
    localparam logic SEL_DATA = 1'b1;

    typedef enum logic [3:0] {
        LK_IDLE,
        LK_ADDR,
        LK_ADDR_ACK,
        LK_RX_DATA,
        LK_RX_HOLD,
        LK_RX_ACK,
        LK_TX_WAIT,
        LK_TX_DATA,
        LK_TX_ACK
    } link_state_t;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_view_t;

    typedef struct packed {
        logic              push;
        logic              first;
        logic [BYTE_W-1:0] data;
    } rx_evt_t;

    typedef struct packed {
        logic fbr;
        logic treq;
        logic rreq;
    } status_t;

    function automatic logic addr_hit(logic [BYTE_W-1:0] frame, logic [ADDR_W-1:0] own);
        return frame[BYTE_W-1:1] == own;
    endfunction

    function automatic logic [BYTE_W-1:0] status_word(status_t s);
        return {{(BYTE_W-3){1'b0}}, s};
    endfunction

endpackage

// File: rtl/i2cs_line_sync.sv
`timescale 1ns/1ps
module i2cs_line_sync
    import i2cs_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      scl_i,
    input  logic      sda_i,
    output bus_view_t view
);
    localparam int TOP = STAGES - 1;

    logic [TOP:0] scl_sh, sda_sh;
    logic         scl_d, sda_d;
    logic         scl_now, sda_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[TOP-1:0], scl_i};
            sda_sh <= {sda_sh[TOP-1:0], sda_i};
            scl_d  <= scl_now;
            sda_d  <= sda_now;
        end
    end

    assign scl_now = scl_sh[TOP];
    assign sda_now = sda_sh[TOP];

    always_comb begin
        view.scl      = scl_now;
        view.sda      = sda_now;
        view.scl_rise = scl_now & ~scl_d;
        view.scl_fall = ~scl_now & scl_d;
        view.start    = scl_now & scl_d & sda_d & ~sda_now;
        view.stop     = scl_now & scl_d & ~sda_d & sda_now;
    end

endmodule

// File: rtl/i2cs_link.sv
`timescale 1ns/1ps
module i2cs_link
    import i2cs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [ADDR_W-1:0] own_addr,
    input  bus_view_t         bv,
    input  logic              rreq,
    input  logic              treq,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              scl_oe,
    output logic              sda_oe,
    output rx_evt_t           rx,
    output logic              tx_set
);
    link_state_t       st_q, st_n;
    logic [BYTE_W-1:0] sh_q, sh_n;
    logic [CNT_W-1:0]  cnt_q, cnt_n;
    logic              fp_q, fp_n;
    logic              mack_q, mack_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= LK_IDLE;
            sh_q   <= '0;
            cnt_q  <= '0;
            fp_q   <= 1'b0;
            mack_q <= 1'b0;
        end else begin
            st_q   <= st_n;
            sh_q   <= sh_n;
            cnt_q  <= cnt_n;
            fp_q   <= fp_n;
            mack_q <= mack_n;
        end
    end

    always_comb begin
        st_n   = st_q;
        sh_n   = sh_q;
        cnt_n  = cnt_q;
        fp_n   = fp_q;
        mack_n = mack_q;
        rx     = '{push: 1'b0, first: fp_q, data: sh_q};
        tx_set = 1'b0;
        if (!en) begin
            st_n = LK_IDLE;
            fp_n = 1'b0;
        end else if (bv.start) begin
            st_n  = LK_ADDR;
            cnt_n = '0;
        end else if (bv.stop) begin
            st_n = LK_IDLE;
        end else begin
            unique case (st_q)
                LK_IDLE: ;
                LK_ADDR, LK_RX_DATA: begin
                    if (bv.scl_rise && cnt_q < CNT_W'(BYTE_W)) begin
                        sh_n  = {sh_q[BYTE_W-2:0], bv.sda};
                        cnt_n = cnt_q + 1'b1;
                    end else if (bv.scl_fall && cnt_q == CNT_W'(BYTE_W)) begin
                        if (st_q == LK_RX_DATA) begin
                            st_n = LK_RX_HOLD;
                        end else if (addr_hit(sh_q, own_addr)) begin
                            st_n = LK_ADDR_ACK;
                            fp_n = ~sh_q[0];
                        end else begin
                            st_n = LK_IDLE;
                        end
                    end
                end
                LK_ADDR_ACK: begin
                    if (bv.scl_fall) begin
                        cnt_n = '0;
                        if (sh_q[0]) begin
                            st_n   = LK_TX_WAIT;
                            tx_set = 1'b1;
                        end else begin
                            st_n = LK_RX_DATA;
                        end
                    end
                end
                LK_RX_HOLD: begin
                    if (!rreq) begin
                        rx.push = 1'b1;
                        fp_n    = 1'b0;
                        st_n    = LK_RX_ACK;
                    end
                end
                LK_RX_ACK: begin
                    if (bv.scl_fall) begin
                        st_n  = LK_RX_DATA;
                        cnt_n = '0;
                    end
                end
                LK_TX_WAIT: begin
                    if (!treq) begin
                        sh_n  = tx_byte;
                        cnt_n = '0;
                        st_n  = LK_TX_DATA;
                    end
                end
                LK_TX_DATA: begin
                    if (bv.scl_fall) begin
                        sh_n  = {sh_q[BYTE_W-2:0], 1'b0};
                        cnt_n = cnt_q + 1'b1;
                        if (cnt_q == CNT_W'(BYTE_W - 1)) st_n = LK_TX_ACK;
                    end
                end
                LK_TX_ACK: begin
                    if (bv.scl_rise) begin
                        mack_n = ~bv.sda;
                    end else if (bv.scl_fall) begin
                        if (mack_q) begin
                            st_n   = LK_TX_WAIT;
                            tx_set = 1'b1;
                        end else begin
                            st_n = LK_IDLE;
                        end
                    end
                end
                default: st_n = LK_IDLE;
            endcase
        end
    end

    assign scl_oe = en && ((st_q == LK_RX_HOLD && rreq) || st_q == LK_TX_WAIT);
    assign sda_oe = en && (st_q == LK_ADDR_ACK || st_q == LK_RX_HOLD ||
                           st_q == LK_RX_ACK || (st_q == LK_TX_DATA && !sh_q[BYTE_W-1]));

    // R4: the target only moves SDA while the synchronized SCL is low
    a_r4_sda_moves_low: assert property (@(posedge clk) disable iff (rst || !en)
        (sda_oe != $past(sda_oe)) |-> !bv.scl);

    // R12: a disabled target drops back to idle
    a_r12_idle_when_off: assert property (@(posedge clk) disable iff (rst)
        !en |=> (st_q == LK_IDLE));

    // R10: a NACK after a sent byte releases the bus without a new request
    a_r10_nack_release: assert property (@(posedge clk) disable iff (rst || !en)
        (st_q == LK_TX_ACK && bv.scl_fall && !mack_q) |=> (!scl_oe && st_q == LK_IDLE));

endmodule

// File: rtl/i2cs_host_regs.sv
`timescale 1ns/1ps
module i2cs_host_regs
    import i2cs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic              rd,
    input  logic              sel,
    input  logic [BYTE_W-1:0] wdata,
    input  rx_evt_t           rx,
    input  logic              tx_set,
    output logic              en,
    output status_t           status,
    output logic [BYTE_W-1:0] data_q,
    output logic [BYTE_W-1:0] rdata
);
    logic wr_ctrl, wr_data, rd_data;

    assign wr_ctrl = wr && sel == SEL_CTRL;
    assign wr_data = wr && sel == SEL_DATA;
    assign rd_data = rd && sel == SEL_DATA;

    always_ff @(posedge clk) begin
        if (rst) begin
            en     <= 1'b0;
            status <= '0;
            data_q <= '0;
        end else begin
            if (wr_ctrl) en <= wdata[0];
            if (wr_data)      data_q <= wdata;
            else if (rx.push) data_q <= rx.data;
            if (!en || (wr_ctrl && !wdata[0])) begin
                status <= '0;
            end else begin
                if (rx.push) begin
                    status.rreq <= 1'b1;
                    status.fbr  <= rx.first;
                end else if (rd_data) begin
                    status.rreq <= 1'b0;
                    status.fbr  <= 1'b0;
                end
                if (tx_set)       status.treq <= 1'b1;
                else if (wr_data) status.treq <= 1'b0;
            end
        end
    end

    assign rdata = (sel == SEL_DATA) ? data_q : status_word(status);

    // R6: the first-byte flag never stands without a receive request
    a_r6_fbr_needs_rreq: assert property (@(posedge clk) disable iff (rst)
        status.fbr |-> status.rreq);

    // R5: a data read with no new byte arriving clears both receive flags
    a_r5_read_clears: assert property (@(posedge clk) disable iff (rst)
        (rd_data && !rx.push) |=> (!status.rreq && !status.fbr));

    // R9: a data write with no new request clears the transmit request
    a_r9_write_clears: assert property (@(posedge clk) disable iff (rst)
        (wr_data && !tx_set) |=> !status.treq);

endmodule

// File: rtl/i2cs_target.sv
`timescale 1ns/1ps
module i2cs_target
    import i2cs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [6:0]  own_addr,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        scl_oe,
    output logic        sda_oe,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic        reg_sel,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata
);
    bus_view_t         bv;
    rx_evt_t           rx;
    status_t           status;
    logic              en, tx_set;
    logic [BYTE_W-1:0] data_q;

    i2cs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .view  (bv)
    );

    i2cs_link u_link (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .own_addr (own_addr),
        .bv       (bv),
        .rreq     (status.rreq),
        .treq     (status.treq),
        .tx_byte  (data_q),
        .scl_oe   (scl_oe),
        .sda_oe   (sda_oe),
        .rx       (rx),
        .tx_set   (tx_set)
    );

    i2cs_host_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr     (reg_wr),
        .rd     (reg_rd),
        .sel    (reg_sel),
        .wdata  (reg_wdata),
        .rx     (rx),
        .tx_set (tx_set),
        .en     (en),
        .status (status),
        .data_q (data_q),
        .rdata  (reg_rdata)
    );

    // R8: a new byte is never stored over one the host has not read
    a_r8_no_overwrite: assert property (@(posedge clk) disable iff (rst)
        rx.push |-> !status.rreq);

    // R9: an outstanding transmit request always holds SCL low
    a_r9_tx_stretch: assert property (@(posedge clk) disable iff (rst)
        status.treq |-> scl_oe);

endmodule

// File: tb/i2cs_target_test.sv
`timescale 1ns/1ps
module i2cs_target_test;

    localparam int Q = 8;
    localparam logic [6:0] OWN = 7'h5A;
    localparam int NV = 6;
    // fields: [15:9] address, [8:1] data byte, [0] expected address ACK
    localparam logic [15:0] VECS [NV] = '{
        {7'h5A, 8'hA5, 1'b1},
        {7'h5B, 8'h11, 1'b0},
        {7'h5A, 8'h00, 1'b1},
        {7'h2D, 8'hFF, 1'b0},
        {7'h5A, 8'h80, 1'b1},
        {7'h1A, 8'h3C, 1'b0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_scl_low = 1'b0, m_sda_low = 1'b0;
    logic scl_oe, sda_oe;
    logic scl, sda;
    logic reg_wr = 1'b0, reg_rd = 1'b0, reg_sel = 1'b0;
    logic [7:0] reg_wdata = '0, reg_rdata;
    int checks = 0, failures = 0;

    always #2 clk = ~clk;

    assign scl = ~(m_scl_low | scl_oe);
    assign sda = ~(m_sda_low | sda_oe);

    i2cs_target #(.SYNC_STAGES(3)) uut (
        .clk(clk), .rst(rst), .own_addr(OWN),
        .scl_i(scl), .sda_i(sda), .scl_oe(scl_oe), .sda_oe(sda_oe),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic m_wait(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic m_wait_scl_high();
        while (scl !== 1'b1) @(negedge clk);
    endtask

    task automatic m_start();
        m_sda_low = 1'b0; m_wait(Q);
        m_scl_low = 1'b0; m_wait_scl_high(); m_wait(Q);
        m_sda_low = 1'b1; m_wait(Q);
        m_scl_low = 1'b1; m_wait(Q);
    endtask

    task automatic m_stop();
        m_sda_low = 1'b1; m_wait(Q);
        m_scl_low = 1'b0; m_wait_scl_high(); m_wait(Q);
        m_sda_low = 1'b0; m_wait(Q);
    endtask

    task automatic m_bit_w(input logic b);
        m_sda_low = ~b; m_wait(Q);
        m_scl_low = 1'b0; m_wait_scl_high(); m_wait(Q);
        m_scl_low = 1'b1; m_wait(Q);
    endtask

    task automatic m_bit_r(output logic b);
        m_sda_low = 1'b0; m_wait(Q);
        m_scl_low = 1'b0; m_wait_scl_high(); m_wait(Q / 2);
        b = sda; m_wait(Q / 2);
        m_scl_low = 1'b1; m_wait(Q);
    endtask

    task automatic m_send(input logic [7:0] d, output logic acked);
        logic b;
        for (int i = 7; i >= 0; i--) m_bit_w(d[i]);
        m_bit_r(b);
        acked = ~b;
    endtask

    task automatic m_recv(output logic [7:0] d, input logic give_ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            m_bit_r(b);
            d[i] = b;
        end
        m_bit_w(~give_ack);
    endtask

    task automatic h_write(input logic sel, input logic [7:0] d);
        @(negedge clk);
        reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic h_read(input logic sel, output logic [7:0] d);
        @(negedge clk);
        reg_sel = sel; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] v, b1, b2;
        logic ack, ack2;
        logic [15:0] vec;

        repeat (5) @(negedge clk);
        rst = 1'b0;
        m_wait(2);

        // R1 reset state
        h_read(1'b0, v);  check("R1 status after reset", v, 8'h00);
        check("R1 scl released", scl_oe, 0);
        check("R1 sda released", sda_oe, 0);

        // R12 disabled after reset: no ACK
        m_start();
        m_send({OWN, 1'b0}, ack);
        check("R12 no ack while disabled", ack, 0);
        m_stop();
        h_read(1'b0, v);  check("R12 status while disabled", v, 8'h00);

        // R2 enable through control location
        h_write(1'b0, 8'h01);

        // R3 R4 R5 R6 vector walk
        for (int k = 0; k < NV; k++) begin
            vec = VECS[k];
            m_start();
            m_send({vec[15:9], 1'b0}, ack);
            check("R3 address ack", ack, vec[0]);
            m_send(vec[8:1], ack2);
            if (vec[0]) begin
                check("R4 data ack", ack2, 1);
                h_read(1'b0, v);  check("R2 R6 status rreq+fbr", v, 8'h05);
                h_read(1'b1, v);  check("R4 data value", v, vec[8:1]);
                h_read(1'b0, v);  check("R5 flags cleared by read", v, 8'h00);
            end else begin
                check("R3 mismatch data not acked", ack2, 0);
                h_read(1'b0, v);  check("R3 mismatch status", v, 8'h00);
            end
            m_stop();
        end

        // R8 stretch while unread, R6 later bytes
        m_start();
        m_send({OWN, 1'b0}, ack);
        m_send(8'h11, ack);
        h_read(1'b0, v);  check("R6 first byte status", v, 8'h05);
        fork
            m_send(8'h22, ack2);
            begin
                while (!scl_oe) @(negedge clk);
                m_wait(20);
                check("R8 scl held low", scl, 0);
                h_read(1'b0, v);  check("R8 status during stall", v, 8'h05);
                h_read(1'b1, v);  check("R8 earlier byte intact", v, 8'h11);
            end
        join
        check("R8 second byte acked", ack2, 1);
        h_read(1'b0, v);  check("R6 second byte no fbr", v, 8'h01);
        h_read(1'b1, v);  check("R8 second byte stored", v, 8'h22);

        // R7 repeated START re-arms first-byte flag
        m_start();
        m_send({OWN, 1'b0}, ack);
        check("R7 readdress ack", ack, 1);
        m_send(8'h33, ack);
        h_read(1'b0, v);  check("R7 fbr re-armed", v, 8'h05);
        h_read(1'b1, v);  check("R7 data", v, 8'h33);
        m_stop();

        // R9 R10 R11 master read
        m_start();
        m_send({OWN, 1'b1}, ack);
        check("R9 read address ack", ack, 1);
        m_wait(10);
        check("R9 scl held for request", scl_oe, 1);
        h_read(1'b0, v);  check("R9 R11 treq only", v, 8'h02);
        fork
            m_recv(b1, 1'b1);
            begin
                m_wait(40);
                check("R9 still stretched", scl, 0);
                h_write(1'b1, 8'hC3);
                m_wait(3);
                h_read(1'b0, v);  check("R9 treq cleared by write", v, 8'h00);
            end
        join
        check("R9 first sent byte", b1, 8'hC3);
        m_wait(10);
        h_read(1'b0, v);  check("R10 ack raises request", v, 8'h02);
        fork
            m_recv(b2, 1'b0);
            begin
                m_wait(40);
                h_write(1'b1, 8'h5E);
            end
        join
        check("R9 second sent byte", b2, 8'h5E);
        m_wait(20);
        h_read(1'b0, v);  check("R10 nack no request", v, 8'h00);
        check("R10 scl released", scl_oe, 0);
        m_stop();
        h_read(1'b0, v);  check("R11 no fbr after read", v, 8'h00);

        // R12 disable clears pending flags and detaches
        m_start();
        m_send({OWN, 1'b0}, ack);
        m_send(8'h44, ack);
        h_read(1'b0, v);  check("R12 pending before disable", v, 8'h05);
        h_write(1'b0, 8'h00);
        h_read(1'b0, v);  check("R12 disable clears flags", v, 8'h00);
        m_stop();
        m_start();
        m_send({OWN, 1'b1}, ack);
        check("R12 no ack after disable", ack, 0);
        m_wait(10);
        check("R12 no stretch after disable", scl_oe, 0);
        m_stop();
        h_read(1'b0, v);  check("R12 status stays clear", v, 8'h00);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule